// File: doc/BRIEF.md
# Remote Terminal Response Decision Controller

This block settles how a remote terminal on a command/response avionics data bus answers a command that the word decoder has already found valid. The decoder pulses `cmd_strobe` at the mid-parity crossing of the command word and presents the transmit/receive direction and the five-bit word-count field. A fixed time later, about 2 us, the block samples the subsystem's active-low busy and illegal levels once. It holds both sampled values for the rest of the message and turns them into the busy and message-error bits of the status word.

For a transmit command that is legal and not busy, the block reports how many data words follow the status word. It then fetches them from the subsystem with one read handshake per word and hands each word to the bus encoder on a valid/ready stream. Busy or illegal reduce the response to the status word alone. For a receive command, busy does not block anything: received words go on to the subsystem's write port. The block also drives the active-low in-command and message-error timing outputs.

The word stream `wd_*` follows valid/ready rules. Once `wd_valid` is high, it stays high and `wd_data` stays unchanged until a cycle with `wd_ready` high. No new read is requested while a word is waiting. The receive path `rx_*` to `sub_wr_*` is a combinational pass-through, so back-pressure from `sub_wr_ready` reaches `rx_ready` in the same cycle.

Top module: `rt_resp_ctrl`

## Requirements
- R1: `busy_n` and `illegal_n` are sampled on the clock edge exactly SAMPLE_CYC cycles after the edge that captured `cmd_strobe` (SAMPLE_CYC = 2*CLK_MHZ, 32 by default). `sts_valid` rises at that same edge.
- R2: `busy_n` sampled low gives `sts_busy`=1. `busy_n` sampled high gives `sts_busy`=0.
- R3: `illegal_n` sampled low gives `sts_me`=1, and `msg_err_n` is low while `sts_me` is valid. `illegal_n` sampled high leaves `sts_me`=0 and `msg_err_n` high.
- R4: After sampling, `sts_busy`, `sts_me` and `tx_count` keep their values until the message ends, whatever the busy and illegal inputs do.
- R5: For a transmit command (`cmd_tx`=1) that is neither busy nor illegal, `tx_count` equals the word-count field, and a field of 0 means 32 words. Exactly `tx_count` read handshakes (`rd_req`&&`rd_gnt`) follow, then `rd_req` stays low.
- R6: For a transmit command sampled busy, illegal or both, `tx_count` is 0 and `rd_req` never rises. When both are sampled asserted, both status bits are set.
- R7: For a receive command (`cmd_tx`=0), `tx_count` is 0, and received words pass to `sub_wr_*` unchanged even when busy is set.
- R8: `incmd_n` goes low on the edge that captures `cmd_strobe` and returns high on the edge that captures `msg_end`, for a valid or an invalid message.
- R9: A word on `wd_data` is the value granted on `rd_data`. It is held stable with `wd_valid` high until `wd_ready` is seen high.
- R10: `msg_end` or a new `cmd_strobe` clears the status, the sampled flags and any read in progress on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_strobe | input | 1 | One-cycle pulse at mid-parity of a valid command |
| cmd_tx | input | 1 | Direction of command, 1 = transmit |
| cmd_wc | input | 5 | Word-count field (0 means 32) |
| msg_end | input | 1 | One-cycle pulse at end of message |
| busy_n | input | 1 | Subsystem busy, active low |
| illegal_n | input | 1 | Subsystem illegal-command flag, active low |
| sts_valid | output | 1 | Status bits and count are decided |
| sts_busy | output | 1 | Status-word busy bit |
| sts_me | output | 1 | Status-word message-error bit |
| tx_count | output | 6 | Data words to send after the status word |
| rd_req | output | 1 | Read request to subsystem |
| rd_gnt | input | 1 | Read grant; `rd_data` valid in this cycle |
| rd_data | input | 16 | Word read from subsystem |
| wd_valid | output | 1 | Transmit word valid toward encoder |
| wd_ready | input | 1 | Encoder accepts transmit word |
| wd_data | output | 16 | Transmit word |
| rx_valid | input | 1 | Received data word valid |
| rx_data | input | 16 | Received data word |
| rx_ready | output | 1 | Received word accepted |
| sub_wr_valid | output | 1 | Write of received word to subsystem |
| sub_wr_data | output | 16 | Data of received word to subsystem |
| sub_wr_ready | input | 1 | Subsystem accepts write |
| incmd_n | output | 1 | Low from command capture to message end |
| msg_err_n | output | 1 | Low while the message-error bit is set |

## Verification
The bench moves `busy_n` one cycle before the sampling edge and again just after it. A design that samples a cycle early or late, or keeps following the level, shows the wrong busy bit. It sends a word count of zero, which a design without the 0-means-32 rule answers with no data or with a short block. It holds `wd_ready` low over several cycles, where a design that drops or changes the waiting word is caught. It also counts read grants against `tx_count` for busy, illegal, combined and receive cases, ends a message in the middle of a read, and feeds received words through under busy, which a design that gates receive on busy would block.

// File: rtl/rt_resp_pkg.sv
package rt_resp_pkg;
  localparam int WC_W  = 5;
  localparam int CNT_W = WC_W + 1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;

  function automatic logic [CNT_W-1:0] words_of(input logic [WC_W-1:0] wc);
    words_of = (wc == '0) ? CNT_W'(1 << WC_W) : {1'b0, wc};
  endfunction
endpackage

// File: rtl/rt_sample_timer.sv
module rt_sample_timer #(
  parameter int SAMPLE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic tick
);
  localparam int CW = $clog2(SAMPLE_CYC + 1);

  logic          running;
  logic [CW-1:0] cnt;

  assign tick = running && (cnt == CW'(SAMPLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (stop || tick) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: the count never runs past the sampling point
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= CW'(SAMPLE_CYC - 1)));
endmodule

// File: rtl/rt_status_dec.sv
module rt_status_dec
  import rt_resp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             clr,
  input  logic             cmd_tx_q,
  input  logic [WC_W-1:0]  cmd_wc_q,
  input  logic             busy_n,
  input  logic             illegal_n,
  output logic             sts_valid,
  output logic             sts_busy,
  output logic             sts_me,
  output logic [CNT_W-1:0] tx_count,
  output logic             decided
);
  logic send_data;
  assign send_data = cmd_tx_q && busy_n && illegal_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_busy  <= 1'b0;
      sts_me    <= 1'b0;
      tx_count  <= '0;
      decided   <= 1'b0;
    end else if (clr) begin
      sts_valid <= 1'b0;
      sts_busy  <= 1'b0;
      sts_me    <= 1'b0;
      tx_count  <= '0;
      decided   <= 1'b0;
    end else begin
      decided <= sample;
      if (sample) begin
        sts_valid <= 1'b1;
        sts_busy  <= ~busy_n;
        sts_me    <= ~illegal_n;
        tx_count  <= send_data ? words_of(cmd_wc_q) : '0;
      end
    end
  end

  // R4: decided status is frozen until cleared
  p_hold_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !clr) |=> (sts_valid && $stable(sts_busy) && $stable(sts_me) && $stable(tx_count)));
  // R6: a status with busy or message error carries no data words
  p_no_words_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy || sts_me) |-> (tx_count == '0));
endmodule

// File: rtl/rt_read_seq.sv
module rt_read_seq
  import rt_resp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  count,
  output logic              rd_req,
  input  logic              rd_gnt,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [WORD_W-1:0] wd_data
);
  seq_state_t       state;
  logic [CNT_W-1:0] remain;

  assign rd_req   = (state == SEQ_REQ);
  assign wd_valid = (state == SEQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      remain  <= '0;
      wd_data <= '0;
    end else if (abort) begin
      state  <= SEQ_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (start && count != '0) begin
          remain <= count;
          state  <= SEQ_REQ;
        end
        SEQ_REQ: if (rd_gnt) begin
          wd_data <= rd_data;
          remain  <= remain - 1'b1;
          state   <= SEQ_HOLD;
        end
        SEQ_HOLD: if (wd_ready) begin
          state <= (remain != '0) ? SEQ_REQ : SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R5: never grants more words than were counted
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_gnt) |-> (remain != '0));
  // R9: a waiting word stays put until accepted
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready && !abort) |=> (wd_valid && $stable(wd_data)));
endmodule

// File: rtl/rt_resp_ctrl.sv
module rt_resp_ctrl
  import rt_resp_pkg::*;
#(
  parameter int CLK_MHZ = 16,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic              cmd_tx,
  input  logic [WC_W-1:0]   cmd_wc,
  input  logic              msg_end,
  input  logic              busy_n,
  input  logic              illegal_n,
  output logic              sts_valid,
  output logic              sts_busy,
  output logic              sts_me,
  output logic [CNT_W-1:0]  tx_count,
  output logic              rd_req,
  input  logic              rd_gnt,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [WORD_W-1:0] wd_data,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              sub_wr_valid,
  output logic [WORD_W-1:0] sub_wr_data,
  input  logic              sub_wr_ready,
  output logic              incmd_n,
  output logic              msg_err_n
);
  localparam int SAMPLE_CYC = 2 * CLK_MHZ;

  logic            cmd_tx_q;
  logic [WC_W-1:0] cmd_wc_q;
  logic            clr;
  logic            tick;
  logic            decided;
  logic            rx_open;

  assign clr = cmd_strobe || msg_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_tx_q <= 1'b0;
      cmd_wc_q <= '0;
      incmd_n  <= 1'b1;
    end else if (cmd_strobe) begin
      cmd_tx_q <= cmd_tx;
      cmd_wc_q <= cmd_wc;
      incmd_n  <= 1'b0;
    end else if (msg_end) begin
      incmd_n <= 1'b1;
    end
  end

  rt_sample_timer #(.SAMPLE_CYC(SAMPLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_strobe), .stop(msg_end), .tick(tick)
  );

  rt_status_dec u_dec (
    .clk(clk), .rst_n(rst_n), .sample(tick), .clr(clr),
    .cmd_tx_q(cmd_tx_q), .cmd_wc_q(cmd_wc_q),
    .busy_n(busy_n), .illegal_n(illegal_n),
    .sts_valid(sts_valid), .sts_busy(sts_busy), .sts_me(sts_me),
    .tx_count(tx_count), .decided(decided)
  );

  rt_read_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(decided), .abort(clr), .count(tx_count),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data)
  );

  assign msg_err_n = !(sts_valid && sts_me);

  // receive words pass regardless of busy
  assign rx_open      = !incmd_n && !cmd_tx_q;
  assign sub_wr_valid = rx_valid && rx_open;
  assign sub_wr_data  = rx_data;
  assign rx_ready     = sub_wr_ready && rx_open;

  // R8: in-command falls only after a captured command
  p_incmd_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(incmd_n) |-> $past(cmd_strobe));
  // R6: reads only for a decided, clean transmit
  p_read_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (sts_valid && !sts_busy && !sts_me && cmd_tx_q));
  // R10: end of message clears status
  p_end_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> (!sts_valid && !rd_req && !wd_valid));
endmodule

// File: tb/rt_resp_ctrl_tb.sv
module rt_resp_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SCYC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_strobe = 0, cmd_tx = 0, msg_end = 0, busy_n = 1, illegal_n = 1;
  logic [4:0] cmd_wc = 0;
  logic sts_valid, sts_busy, sts_me, rd_req, wd_valid, rx_ready, sub_wr_valid, incmd_n, msg_err_n;
  logic [5:0] tx_count;
  logic rd_gnt = 0, wd_ready = 0, rx_valid = 0, sub_wr_ready = 0;
  logic [15:0] rd_data = 0, rx_data = 0, wd_data, sub_wr_data;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_resp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_tx(cmd_tx), .cmd_wc(cmd_wc),
    .msg_end(msg_end), .busy_n(busy_n), .illegal_n(illegal_n),
    .sts_valid(sts_valid), .sts_busy(sts_busy), .sts_me(sts_me), .tx_count(tx_count),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sub_wr_valid(sub_wr_valid), .sub_wr_data(sub_wr_data), .sub_wr_ready(sub_wr_ready),
    .incmd_n(incmd_n), .msg_err_n(msg_err_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      finish_run();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe captured at next edge E0; returns at negedge after E0
  task automatic send_cmd(input logic tx, input logic [4:0] wc);
    @(negedge clk);
    cmd_strobe = 1; cmd_tx = tx; cmd_wc = wc;
    @(negedge clk);
    cmd_strobe = 0;
  endtask

  task automatic end_msg();
    msg_end = 1;
    @(negedge clk);
    msg_end = 0;
  endtask

  // serve reads; count grants up to a window with no request
  task automatic serve_reads(input int idle_lim, input int stall, output int got, output int bad_data);
    int idle = 0;
    got = 0; bad_data = 0;
    while (idle < idle_lim) begin
      if (rd_req) begin
        idle = 0;
        rd_gnt = 1; rd_data = 16'hA500 + 16'(got);
        @(negedge clk);
        rd_gnt = 0;
        for (int s = 0; s < stall; s++) begin
          if (!wd_valid || wd_data !== 16'hA500 + 16'(got)) bad_data++;
          @(negedge clk);
        end
        if (!wd_valid || wd_data !== 16'hA500 + 16'(got)) bad_data++;
        wd_ready = 1;
        @(negedge clk);
        wd_ready = 0;
        got++;
      end else begin
        idle++;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk("R8 reset incmd_n", incmd_n, 1);
    chk("R1 reset sts_valid", sts_valid, 0);
    chk("R3 reset msg_err_n", msg_err_n, 1);
    chk("R5 reset rd_req", rd_req, 0);
  endtask

  task automatic t_sample_edge();
    busy_n = 1; illegal_n = 1;
    send_cmd(1, 5'd3);
    chk("R8 incmd_n low after strobe", incmd_n, 0);
    cycles(SCYC - 1);
    chk("R1 not yet sampled", sts_valid, 0);
    busy_n = 0;
    cycles(1);
    chk("R1 sampled at delay", sts_valid, 1);
    chk("R2 busy bit set", sts_busy, 1);
    chk("R6 busy tx count", tx_count, 0);
    busy_n = 1; illegal_n = 0;
    cycles(5);
    chk("R4 busy held", sts_busy, 1);
    chk("R4 me held", sts_me, 0);
    chk("R6 no read when busy", rd_req, 0);
    end_msg();
    chk("R8 incmd_n high at end", incmd_n, 1);
    chk("R10 status cleared", sts_valid, 0);
    illegal_n = 1;
  endtask

  task automatic t_clean_tx(input logic [4:0] wc, input int exp_n, input int stall);
    int got, bd;
    busy_n = 1; illegal_n = 1;
    send_cmd(1, wc);
    cycles(SCYC);
    chk("R2 busy clear", sts_busy, 0);
    chk("R3 me clear", sts_me, 0);
    chk("R3 msg_err_n high", msg_err_n, 1);
    chk("R5 tx_count", tx_count, exp_n);
    serve_reads(8, stall, got, bd);
    chk("R5 read handshakes", got, exp_n);
    chk("R9 word data and hold", bd, 0);
    end_msg();
  endtask

  task automatic t_flagged_tx(input logic b, input logic il);
    int got, bd;
    busy_n = b; illegal_n = il;
    send_cmd(1, 5'd4);
    cycles(SCYC);
    chk("R2 busy bit", sts_busy, !b);
    chk("R3 me bit", sts_me, !il);
    chk("R3 msg_err_n", msg_err_n, il);
    chk("R6 flagged tx_count", tx_count, 0);
    serve_reads(10, 0, got, bd);
    chk("R6 flagged no reads", got, 0);
    end_msg();
    chk("R10 msg_err_n released", msg_err_n, 1);
    busy_n = 1; illegal_n = 1;
  endtask

  task automatic t_rx_busy();
    busy_n = 0;
    send_cmd(0, 5'd2);
    cycles(SCYC);
    chk("R7 rx busy bit", sts_busy, 1);
    chk("R7 rx tx_count", tx_count, 0);
    rx_valid = 1; rx_data = 16'h3C5A; sub_wr_ready = 1;
    #1;
    chk("R7 rx write valid", sub_wr_valid, 1);
    chk("R7 rx write data", sub_wr_data, 16'h3C5A);
    chk("R7 rx ready", rx_ready, 1);
    sub_wr_ready = 0;
    #1;
    chk("R7 rx backpressure", rx_ready, 0);
    rx_valid = 0;
    busy_n = 1;
    end_msg();
  endtask

  task automatic t_abort();
    busy_n = 1; illegal_n = 1;
    send_cmd(1, 5'd6);
    cycles(SCYC + 3);
    chk("R5 request pending", rd_req, 1);
    end_msg();
    chk("R10 abort clears read", rd_req, 0);
    chk("R10 abort clears word", wd_valid, 0);
    cycles(4);
    chk("R10 stays idle", rd_req, 0);
    // new command mid-message restarts the decision
    send_cmd(1, 5'd2);
    cycles(SCYC - 4);
    send_cmd(1, 5'd1);
    cycles(SCYC - 1);
    chk("R10 restart delays sample", sts_valid, 0);
    cycles(1);
    chk("R10 restart samples", tx_count, 1);
    end_msg();
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1;
    cycles(2);
    t_sample_edge();
    t_clean_tx(5'd3, 3, 3);
    t_clean_tx(5'd0, 32, 0);
    t_flagged_tx(1, 0);
    t_flagged_tx(0, 0);
    t_rx_busy();
    t_abort();
    finish_run();
  end
endmodule